// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the entry into an exception handler on behalf of a processor core. A fault source (illegal opcode, privilege violation and the like) hands it a vector number and the program counter to preserve. For faults this is the address of the first word of the offending instruction. The sequencer then takes a private copy of the status register, forces supervisor mode on and tracing off, and pushes three 16-bit words onto the supervisor stack through a word-wide write/read memory port: the saved PC low half, the saved PC high half, and the status copy. It then reads the 32-bit handler address from the vector table and presents it as the new PC with a one-cycle load strobe.

The block also raises trace exceptions. At every instruction start it latches the trace bit. When that instruction completes and the latched bit was one, it records the next-instruction address and posts a trace request. It serves that request itself as an entry with vector 9. A trace-bit change made during the instruction does not affect the decision for it. The status register lives in the block, and the core updates it through a simple write port.

The machine has seven states:
- IDLE goes to PUSH_PCL on an accepted request.
- PUSH_PCL goes to PUSH_PCH, PUSH_PCH goes to PUSH_SR, PUSH_SR goes to VEC_HI, and VEC_HI goes to VEC_LO. Each of these steps happens on a memory handshake.
- VEC_LO goes to LOAD_PC on its handshake.
- LOAD_PC goes back to IDLE unconditionally.

Addresses are byte addresses, and the address width is twice the word width.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `sr` equals SR_RESET (default 0x2700), `ssp` equals SSP_RESET (default 0x0001_0000), and `busy`, `mem_valid`, `trace_req` and `pc_load` are 0.
- R2: In IDLE, a high `req_valid` is accepted at the clock edge. `busy` is high from the next cycle and stays high through the one-cycle `pc_load` pulse. It is low in the cycle after that pulse.
- R3: At acceptance the pre-change status value is kept as the snapshot. In the following cycle `sr` has bit 13 (supervisor) set and bit 15 (trace) cleared, with all other bits unchanged.
- R4: The entry performs three writes in this order: SSP-2 with saved PC bits 15:0, SSP-4 with bits 31:16, and SSP-6 with the status snapshot. `ssp` ends at SSP-6. For requests the saved PC is `req_pc` unchanged.
- R5: After the pushes, the block reads word address vector*4 (the high half) and then vector*4+2 (the low half). It then drives `pc_out` = {high, low} with `pc_load` high for one cycle.
- R6: Each access holds `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` steady until a cycle with `mem_ready` high. The sequence does not advance before that cycle.
- R7: `req_valid` while `busy` is high is ignored: it causes no memory access and no change to `ssp`.
- R8: `sr_wr_en` loads `sr_wr_data` into `sr` at the next edge when the block is idle and not accepting. It is ignored while busy.
- R9: Bit 15 of `sr` is latched at `instr_start`, using the value before any write in that same cycle. An `instr_done` with a latched 1 raises `trace_req` in the next cycle. With a latched 0 it raises nothing.
- R10: A pending trace is entered as vector 9 with saved PC equal to the `next_pc` given with `instr_done`. `trace_req` clears when that entry is accepted.
- R11: When a request and a pending trace compete in IDLE, the request is taken first. The trace entry follows when the block returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception entry request |
| req_vector | input | VW | Vector number of the request |
| req_pc | input | AW | PC to save for the request |
| instr_start | input | 1 | Pulse: an instruction begins |
| instr_done | input | 1 | Pulse: an instruction completes |
| next_pc | input | AW | Next-instruction address, valid with instr_done |
| sr_wr_en | input | 1 | Status register write strobe |
| sr_wr_data | input | DW | Status register write value |
| sr | output | DW | Current status register |
| ssp | output | AW | Supervisor stack pointer |
| busy | output | 1 | Entry in progress |
| trace_req | output | 1 | Trace exception pending |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| pc_load | output | 1 | New PC strobe |
| pc_out | output | AW | Handler address |

## Verification
Two pairs of functions can fall in the same cycle, and the bench provokes both.

The first pair is the trace-bit latch and a status write. The bench drives `instr_start` together with an `sr_wr_en` that flips bit 15, in both directions. It judges the result by whether a vector-9 entry with the given next PC appears on the memory port.

The second pair is a fresh request and the posting of a trace. The bench raises `req_valid` in the same cycle as an `instr_done` whose trace bit was latched. The scoreboard then requires the request's full push-and-fetch sequence first, followed by the trace entry whose snapshot already has supervisor set and trace clear.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PCL,
        ST_PUSH_PCH,
        ST_PUSH_SR,
        ST_VEC_HI,
        ST_VEC_LO,
        ST_LOAD_PC
    } exc_state_t;

endpackage

// File: rtl/exc_status_unit.sv
module exc_status_unit #(
    parameter int DW = 16,
    parameter int S_BIT = 13,
    parameter int T_BIT = 15,
    parameter logic [DW-1:0] SR_RESET = 16'h2700
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          busy,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] sr,
    output logic [DW-1:0] sr_copy
);

    localparam logic [DW-1:0] ONE    = {{(DW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] S_MASK = ONE << S_BIT;
    localparam logic [DW-1:0] T_MASK = ONE << T_BIT;

    // Snapshot first, then force supervisor on and trace off in the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr      <= SR_RESET;
            sr_copy <= '0;
        end else if (take) begin
            sr_copy <= sr;
            sr      <= (sr | S_MASK) & ~T_MASK;
        end else if (wr_en && !busy) begin
            sr      <= wr_data;
        end
    end

endmodule

// File: rtl/exc_trace_unit.sv
module exc_trace_unit #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          t_now,
    input  logic          instr_start,
    input  logic          instr_done,
    input  logic [AW-1:0] next_pc,
    input  logic          take_trace,
    output logic          pend,
    output logic [AW-1:0] pend_pc
);

    logic t_at_start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_at_start <= 1'b0;
        end else if (instr_start) begin
            t_at_start <= t_now;
        end
    end

    // A newly posted trace has priority over clearing the one being taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            pend_pc <= '0;
        end else if (instr_done && t_at_start) begin
            pend    <= 1'b1;
            pend_pc <= next_pc;
        end else if (take_trace) begin
            pend    <= 1'b0;
        end
    end

endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
    import exc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int VW = 8,
    parameter logic [AW-1:0] SSP_RESET = 32'h0001_0000,
    parameter logic [VW-1:0] TRACE_VEC = 8'd9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [VW-1:0] req_vector,
    input  logic [AW-1:0] req_pc,
    input  logic          trc_pend,
    input  logic [AW-1:0] trc_pc,
    input  logic [DW-1:0] sr_copy,
    output logic          take,
    output logic          take_trace,
    output logic          busy,
    output logic [AW-1:0] ssp,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          pc_load,
    output logic [AW-1:0] pc_out
);

    localparam logic [AW-1:0] STEP = AW'(2);
    localparam int PAD = AW - VW - 2;

    exc_state_t    state, state_nx;
    logic [VW-1:0] vec_r;
    logic [AW-1:0] save_pc;
    logic [AW-1:0] ssp_r;
    logic [DW-1:0] hi_r;
    logic [AW-1:0] pc_r;
    logic [AW-1:0] vec_base;

    // External requests win over a pending trace.
    assign take       = (state == ST_IDLE) && (req_valid || trc_pend);
    assign take_trace = (state == ST_IDLE) && !req_valid && trc_pend;
    assign vec_base   = {{PAD{1'b0}}, vec_r, 2'b00};

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (take)      state_nx = ST_PUSH_PCL;
            ST_PUSH_PCL: if (mem_ready) state_nx = ST_PUSH_PCH;
            ST_PUSH_PCH: if (mem_ready) state_nx = ST_PUSH_SR;
            ST_PUSH_SR:  if (mem_ready) state_nx = ST_VEC_HI;
            ST_VEC_HI:   if (mem_ready) state_nx = ST_VEC_LO;
            ST_VEC_LO:   if (mem_ready) state_nx = ST_LOAD_PC;
            ST_LOAD_PC:                 state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_r   <= '0;
            save_pc <= '0;
            ssp_r   <= SSP_RESET;
            hi_r    <= '0;
            pc_r    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        vec_r   <= req_valid ? req_vector : TRACE_VEC;
                        save_pc <= req_valid ? req_pc : trc_pc;
                        ssp_r   <= ssp_r - STEP;
                    end
                end
                ST_PUSH_PCL, ST_PUSH_PCH: begin
                    if (mem_ready) ssp_r <= ssp_r - STEP;
                end
                ST_VEC_HI: begin
                    if (mem_ready) hi_r <= mem_rdata;
                end
                ST_VEC_LO: begin
                    if (mem_ready) pc_r <= {hi_r, mem_rdata};
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = ssp_r;
        mem_wdata = '0;
        unique case (state)
            ST_PUSH_PCL: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_wdata = save_pc[DW-1:0];
            end
            ST_PUSH_PCH: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_wdata = save_pc[AW-1:DW];
            end
            ST_PUSH_SR: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_wdata = sr_copy;
            end
            ST_VEC_HI: begin
                mem_valid = 1'b1;
                mem_addr  = vec_base;
            end
            ST_VEC_LO: begin
                mem_valid = 1'b1;
                mem_addr  = vec_base + STEP;
            end
            default: begin
            end
        endcase
    end

    assign busy    = (state != ST_IDLE);
    assign pc_load = (state == ST_LOAD_PC);
    assign pc_out  = pc_r;
    assign ssp     = ssp_r;

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int VW = 8,
    parameter int S_BIT = 13,
    parameter int T_BIT = 15,
    parameter logic [DW-1:0] SR_RESET = 16'h2700,
    parameter logic [AW-1:0] SSP_RESET = 32'h0001_0000,
    parameter logic [VW-1:0] TRACE_VEC = 8'd9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [VW-1:0] req_vector,
    input  logic [AW-1:0] req_pc,
    input  logic          instr_start,
    input  logic          instr_done,
    input  logic [AW-1:0] next_pc,
    input  logic          sr_wr_en,
    input  logic [DW-1:0] sr_wr_data,
    output logic [DW-1:0] sr,
    output logic [AW-1:0] ssp,
    output logic          busy,
    output logic          trace_req,
    output logic          mem_valid,
    output logic          mem_write,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          pc_load,
    output logic [AW-1:0] pc_out
);

    logic          take;
    logic          take_trace;
    logic [DW-1:0] sr_copy;
    logic [AW-1:0] trc_pc;

    exc_status_unit #(
        .DW(DW), .S_BIT(S_BIT), .T_BIT(T_BIT), .SR_RESET(SR_RESET)
    ) u_status (
        .clk(clk), .rst_n(rst_n), .take(take), .busy(busy),
        .wr_en(sr_wr_en), .wr_data(sr_wr_data),
        .sr(sr), .sr_copy(sr_copy)
    );

    exc_trace_unit #(.AW(AW)) u_trace (
        .clk(clk), .rst_n(rst_n), .t_now(sr[T_BIT]),
        .instr_start(instr_start), .instr_done(instr_done),
        .next_pc(next_pc), .take_trace(take_trace),
        .pend(trace_req), .pend_pc(trc_pc)
    );

    exc_entry_fsm #(
        .AW(AW), .DW(DW), .VW(VW), .SSP_RESET(SSP_RESET), .TRACE_VEC(TRACE_VEC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vector(req_vector), .req_pc(req_pc),
        .trc_pend(trace_req), .trc_pc(trc_pc), .sr_copy(sr_copy),
        .take(take), .take_trace(take_trace), .busy(busy), .ssp(ssp),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .pc_load(pc_load), .pc_out(pc_out)
    );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int S_BIT = 13,
    parameter int T_BIT = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          mem_write,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          pc_load,
    input logic [DW-1:0] sr,
    input logic          trace_req,
    input logic          instr_done
);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_write) && $stable(mem_wdata));

    assert_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> sr[S_BIT] && !sr[T_BIT]);

    assert_busy_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !pc_load |=> busy);

    assert_busy_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

    assert_first_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_valid && mem_write);

    assert_load_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !mem_valid);

    assert_sr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sr));

    assert_trace_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trace_req) |-> $past(instr_done));

endmodule

bind exc_entry_seq exc_entry_chk #(
    .AW(AW), .DW(DW), .S_BIT(S_BIT), .T_BIT(T_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pc_load(pc_load), .sr(sr),
    .trace_req(trace_req), .instr_done(instr_done)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

    typedef struct packed {
        logic        is_pc;
        logic        wr;
        logic [31:0] addr;
        logic [31:0] data;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic [31:0] req_pc = '0;
    logic        instr_start = 1'b0;
    logic        instr_done = 1'b0;
    logic [31:0] next_pc = '0;
    logic        sr_wr_en = 1'b0;
    logic [15:0] sr_wr_data = '0;
    logic [15:0] sr;
    logic [31:0] ssp;
    logic        busy, trace_req, mem_valid, mem_write, pc_load;
    logic [31:0] mem_addr, pc_out;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int delay = 0;
    int wcnt = 0;
    int cyc = 0;
    logic [31:0] ssp_m = 32'h0001_0000;
    item_t exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_pc(req_pc), .instr_start(instr_start), .instr_done(instr_done),
        .next_pc(next_pc), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .sr(sr), .ssp(ssp), .busy(busy), .trace_req(trace_req),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .pc_load(pc_load), .pc_out(pc_out)
    );

    function automatic logic [15:0] memf(input logic [31:0] a);
        return a[15:0] ^ 16'h6B2D;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic expect_entry(input logic [7:0] vec, input logic [31:0] pc,
                                input logic [15:0] src, input string rq);
        logic [31:0] va;
        va = {22'b0, vec, 2'b00};
        ssp_m = ssp_m - 2;
        exp_q.push_back('{1'b0, 1'b1, ssp_m, {16'h0, pc[15:0]}}); tag_q.push_back({rq, " R4 push pc low"});
        ssp_m = ssp_m - 2;
        exp_q.push_back('{1'b0, 1'b1, ssp_m, {16'h0, pc[31:16]}}); tag_q.push_back({rq, " R4 push pc high"});
        ssp_m = ssp_m - 2;
        exp_q.push_back('{1'b0, 1'b1, ssp_m, {16'h0, src}}); tag_q.push_back({rq, " R4 push sr"});
        exp_q.push_back('{1'b0, 1'b0, va, 32'h0}); tag_q.push_back({rq, " R5 read vec hi"});
        exp_q.push_back('{1'b0, 1'b0, va + 2, 32'h0}); tag_q.push_back({rq, " R5 read vec lo"});
        exp_q.push_back('{1'b1, 1'b0, 32'h0, {memf(va), memf(va + 2)}}); tag_q.push_back({rq, " R5 pc load"});
    endtask

    // Monitor and memory responder: pops the scoreboard on every completed access.
    always @(negedge clk) begin
        item_t it;
        string tg;
        if (rst_n && mem_valid) begin
            if (wcnt >= delay) begin
                mem_ready = 1'b1;
                mem_rdata = memf(mem_addr);
                wcnt = 0;
                if (exp_q.size() == 0) begin
                    chk("R7", mem_addr, 32'hFFFF_FFFF, "unexpected access addr");
                end else begin
                    it = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(tg, {31'h0, it.is_pc}, 32'h0, "kind");
                    chk(tg, {31'h0, mem_write}, {31'h0, it.wr}, "write flag");
                    chk(tg, mem_addr, it.addr, "addr");
                    if (it.wr) chk(tg, {16'h0, mem_wdata}, it.data, "wdata");
                end
            end else begin
                mem_ready = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ready = 1'b0;
        end
        if (rst_n && pc_load) begin
            if (exp_q.size() == 0) begin
                chk("R5", pc_out, 32'hFFFF_FFFF, "unexpected pc_load");
            end else begin
                it = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk(tg, {31'h0, it.is_pc}, 32'h1, "kind");
                chk(tg, pc_out, it.data, "pc_out");
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog actual=%0d expected<20000 cycles", cyc);
            finish_run();
        end
    end

    task automatic wait_idle();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (busy && n < 300);
    endtask

    task automatic send_req(input logic [7:0] vec, input logic [31:0] pc);
        @(negedge clk);
        req_valid = 1'b1; req_vector = vec; req_pc = pc;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", {31'h0, busy}, 32'h1, "busy after accept");
    endtask

    task automatic write_sr(input logic [15:0] v);
        @(negedge clk);
        sr_wr_en = 1'b1; sr_wr_data = v;
        @(negedge clk);
        sr_wr_en = 1'b0;
        chk("R8", {16'h0, sr}, {16'h0, v}, "sr after idle write");
    endtask

    task automatic pulse_start();
        @(negedge clk); instr_start = 1'b1;
        @(negedge clk); instr_start = 1'b0;
    endtask

    task automatic pulse_done(input logic [31:0] np);
        @(negedge clk); instr_done = 1'b1; next_pc = np;
        @(negedge clk); instr_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", {16'h0, sr}, 32'h2700, "sr reset");
        chk("R1", ssp, 32'h0001_0000, "ssp reset");
        chk("R1", {28'h0, busy, mem_valid, trace_req, pc_load}, 32'h0, "control outputs");

        // Illegal-opcode style entry, zero wait states.
        write_sr(16'h0000);
        delay = 0;
        expect_entry(8'd4, 32'h0001_1230, 16'h0000, "R4");
        send_req(8'd4, 32'h0001_1230);
        wait_idle();
        chk("R3", {16'h0, sr}, 32'h2000, "sr after entry");
        chk("R4", ssp, ssp_m, "ssp after entry");
        chk("R2", {31'h0, busy}, 32'h0, "busy after pc_load");

        // Privilege entry with trace on and two wait states per access.
        write_sr(16'h8005);
        delay = 2;
        expect_entry(8'd8, 32'h00AB_C004, 16'h8005, "R6");
        send_req(8'd8, 32'h00AB_C004);
        wait_idle();
        chk("R3", {16'h0, sr}, 32'h2005, "sr bits kept, S set, T cleared");
        delay = 1;

        // R7: requests while busy are ignored; R8: sr writes while busy ignored.
        write_sr(16'h0000);
        expect_entry(8'd33, 32'h1234_5678, 16'h0000, "R7");
        send_req(8'd33, 32'h1234_5678);
        req_valid = 1'b1; req_vector = 8'd5; req_pc = 32'hDEAD_0000;
        sr_wr_en = 1'b1; sr_wr_data = 16'hFFFF;
        repeat (3) @(negedge clk);
        req_valid = 1'b0; sr_wr_en = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R7", ssp, ssp_m, "ssp after ignored request");
        chk("R7", {31'h0, busy}, 32'h0, "no second entry");
        chk("R8", {16'h0, sr}, 32'h2000, "sr write ignored while busy");

        // R9: trace off at start, turned on in the same cycle: no trace.
        write_sr(16'h0000);
        @(negedge clk);
        instr_start = 1'b1; sr_wr_en = 1'b1; sr_wr_data = 16'h8000;
        @(negedge clk);
        instr_start = 1'b0; sr_wr_en = 1'b0;
        pulse_done(32'h0000_4444);
        repeat (2) @(negedge clk);
        chk("R9", {30'h0, trace_req, busy}, 32'h0, "no trace when latched bit was 0");

        // R9/R10: trace on at start, cleared in the same cycle: trace fires.
        expect_entry(8'd9, 32'h0003_0100, 16'h0000, "R10");
        @(negedge clk);
        instr_start = 1'b1; sr_wr_en = 1'b1; sr_wr_data = 16'h0000;
        @(negedge clk);
        instr_start = 1'b0; sr_wr_en = 1'b0;
        @(negedge clk);
        instr_done = 1'b1; next_pc = 32'h0003_0100;
        @(negedge clk);
        instr_done = 1'b0;
        chk("R9", {31'h0, trace_req}, 32'h1, "trace_req after done");
        wait_idle();
        chk("R10", {31'h0, trace_req}, 32'h0, "trace_req cleared");
        chk("R10", ssp, ssp_m, "ssp after trace entry");

        // R11: request and trace posting in the same cycle.
        write_sr(16'h8000);
        pulse_start();
        expect_entry(8'd11, 32'h0000_0A0A, 16'h8000, "R11");
        expect_entry(8'd9, 32'h0005_5550, 16'h2000, "R11");
        @(negedge clk);
        req_valid = 1'b1; req_vector = 8'd11; req_pc = 32'h0000_0A0A;
        instr_done = 1'b1; next_pc = 32'h0005_5550;
        @(negedge clk);
        req_valid = 1'b0; instr_done = 1'b0;
        chk("R11", {30'h0, busy, trace_req}, 32'h3, "request first, trace held");
        wait_idle();
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R11", {30'h0, busy, trace_req}, 32'h0, "both entries done");
        chk("R11", ssp, ssp_m, "ssp after two entries");
        chk("R11", exp_q.size(), 32'h0, "scoreboard drained");
        finish_run();
    end

endmodule